// File: doc/BRIEF.md
# Log-Quantized Shift-Accumulate Processing Element

This block is the multiply-and-accumulate element of a convolution datapath. Each weight is a short logarithmic code: one sign bit and a small index. The weight's magnitude is a power of two. Its exponent is a scale coefficient times the index plus a fixed offset. The element never multiplies. It forms each product by shifting a signed activation, negating the result when the sign bit is set, and adding it into a saturating signed accumulator.

When the scale coefficient is above one, the exponent steps over some powers of two. The shifter is built only for the distances that can be reached: one mux stage per index bit, each moving by a multiple of the scale, plus one fixed stage for the offset. No code stands for zero, so every code shifts. A clear input starts a new sum. The product is registered once before the adder.

Top module: `lqpe_top`

## Requirements
- R1: While reset is low, and in the first cycle after reset releases, `acc_o` is 0 and `out_valid_o` is 0.
- R2: `w_code_i[2:0]` is the index x and `w_code_i[3]` is the sign. The weight exponent is SCALE*x + OFFSET (defaults 2 and -4, giving exponents -4 to 10). A non-negative exponent shifts the activation left.
- R3: A negative exponent is an arithmetic right shift. The product is floor(act / 2^-e), so -1 with exponent -4 gives -1 and 7 gives 0.
- R4: When `w_code_i[3]` is 1, the shifted value is negated in two's complement before it is accumulated.
- R5: A cycle with `in_valid_i` low and `clr_i` low leaves `acc_o` unchanged, whatever the activation and code are.
- R6: `clr_i` with `in_valid_i` high loads the accumulator with that cycle's product and drops the previous sum.
- R7: `clr_i` with `in_valid_i` low loads the accumulator with zero.
- R8: The accumulator saturates at +8388607 and -8388608 instead of wrapping. After saturation, a product of the opposite sign moves it off the limit again.
- R9: `acc_o` reflects an input on the second rising edge after it is presented. `out_valid_o` is high for exactly one cycle after that edge for each valid input.
- R10: Index 0 encodes the smallest power of two, 2^-4, not zero. An activation of 16 with code 0 adds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Activation and weight code are valid this cycle |
| clr_i | input | 1 | Start a new accumulation with this cycle's input |
| act_i | input | 8 | Signed activation |
| w_code_i | input | 4 | Weight code: sign in bit 3, index in bits 2:0 |
| acc_o | output | 24 | Signed running accumulation |
| out_valid_o | output | 1 | Accumulator has just absorbed a valid product |

## Verification
The hardest state to reach from the ports is the saturation limit. Even the largest product of magnitude 131072 takes about 64 unbroken valid cycles to reach the 24-bit bounds. The bench streams 70 back-to-back maximum products of each sign after a clear and checks that the sum pins to each limit. It then adds a small product of the opposite sign to show the limit is not sticky. Floor rounding of negative activations under right shifts is covered by table vectors that pair small negative activations with index 0 and index 1.

// File: rtl/lqpe_pkg.sv
package lqpe_pkg;

    localparam int ACT_W_DEF  = 8;
    localparam int ACC_W_DEF  = 24;
    localparam int IDX_W_DEF  = 3;
    localparam int SCALE_DEF  = 2;
    localparam int OFFSET_DEF = -4;

    // largest left shift contributed by the index stages
    function automatic int idx_shift_max(input int scale, input int idx_w);
        return scale * ((1 << idx_w) - 1);
    endfunction

    function automatic int pos_part(input int v);
        return (v > 0) ? v : 0;
    endfunction

    function automatic int neg_part(input int v);
        return (v < 0) ? -v : 0;
    endfunction

endpackage

// File: rtl/lqpe_decode.sv
module lqpe_decode #(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W:0]   code_i,
    output logic [IDX_W-1:0] stage_en_o,
    output logic             negate_o
);

    always_comb begin
        stage_en_o = code_i[IDX_W-1:0];
        unique case (code_i[IDX_W])
            1'b0:    negate_o = 1'b0;
            default: negate_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/lqpe_shifter.sv
module lqpe_shifter #(
    parameter int ACT_W  = 8,
    parameter int IDX_W  = 3,
    parameter int SCALE  = 2,
    parameter int OFFSET = -4,
    localparam int LOFF  = lqpe_pkg::pos_part(OFFSET),
    localparam int ROFF  = lqpe_pkg::neg_part(OFFSET),
    localparam int WIDE_W = ACT_W + lqpe_pkg::idx_shift_max(SCALE, IDX_W) + LOFF,
    localparam int MAG_W = WIDE_W - ROFF
) (
    input  logic signed [ACT_W-1:0] act_i,
    input  logic        [IDX_W-1:0] stage_en_i,
    output logic signed [MAG_W-1:0] mag_o
);

    logic signed [WIDE_W-1:0] stage [0:IDX_W];
    logic signed [WIDE_W-1:0] off_out;

    assign stage[0] = WIDE_W'(act_i);

    // each index bit moves by SCALE * 2^k, so only reachable distances exist
    for (genvar k = 0; k < IDX_W; k++) begin : g_stage
        assign stage[k+1] = stage_en_i[k] ? (stage[k] <<< (SCALE * (1 << k)))
                                          : stage[k];
    end

    // fixed offset stage, applied after the left shifts so rounding is a floor
    if (ROFF > 0) begin : g_right
        assign off_out = stage[IDX_W] >>> ROFF;
    end else begin : g_left
        assign off_out = stage[IDX_W] <<< LOFF;
    end

    assign mag_o = $signed(off_out[MAG_W-1:0]);

endmodule

// File: rtl/lqpe_accum.sv
module lqpe_accum #(
    parameter int ACC_W  = 24,
    parameter int PROD_W = 19,
    localparam int SUM_W = ACC_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic                     clr_i,
    input  logic signed [PROD_W-1:0] prod_i,
    output logic signed [ACC_W-1:0]  acc_o,
    output logic                     out_valid_o
);

    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [SUM_W-1:0] sum;
    logic signed [ACC_W-1:0] sat_sum;
    logic signed [ACC_W-1:0] acc_d;

    always_comb begin
        sum = SUM_W'(acc_o) + SUM_W'(prod_i);
        unique case (sum[SUM_W-1:SUM_W-2])
            2'b01:   sat_sum = ACC_MAX;
            2'b10:   sat_sum = ACC_MIN;
            default: sat_sum = sum[ACC_W-1:0];
        endcase
    end

    always_comb begin
        unique case ({clr_i, vld_i})
            2'b11:   acc_d = ACC_W'(prod_i);
            2'b10:   acc_d = '0;
            2'b01:   acc_d = sat_sum;
            default: acc_d = acc_o;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o       <= '0;
            out_valid_o <= 1'b0;
        end else begin
            acc_o       <= acc_d;
            out_valid_o <= vld_i;
        end
    end

endmodule

// File: rtl/lqpe_top.sv
module lqpe_top #(
    parameter int ACT_W  = lqpe_pkg::ACT_W_DEF,
    parameter int ACC_W  = lqpe_pkg::ACC_W_DEF,
    parameter int IDX_W  = lqpe_pkg::IDX_W_DEF,
    parameter int SCALE  = lqpe_pkg::SCALE_DEF,
    parameter int OFFSET = lqpe_pkg::OFFSET_DEF,
    localparam int WIDE_W = ACT_W + lqpe_pkg::idx_shift_max(SCALE, IDX_W)
                          + lqpe_pkg::pos_part(OFFSET),
    localparam int MAG_W  = WIDE_W - lqpe_pkg::neg_part(OFFSET),
    localparam int PROD_W = MAG_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid_i,
    input  logic                    clr_i,
    input  logic signed [ACT_W-1:0] act_i,
    input  logic        [IDX_W:0]   w_code_i,
    output logic signed [ACC_W-1:0] acc_o,
    output logic                    out_valid_o
);

    logic        [IDX_W-1:0]  stage_en;
    logic                     negate;
    logic signed [MAG_W-1:0]  mag;
    logic signed [PROD_W-1:0] mag_ext;
    logic signed [PROD_W-1:0] prod_d;
    logic signed [PROD_W-1:0] prod_q;
    logic                     vld_q;
    logic                     clr_q;

    lqpe_decode #(.IDX_W(IDX_W)) u_dec (
        .code_i     (w_code_i),
        .stage_en_o (stage_en),
        .negate_o   (negate)
    );

    lqpe_shifter #(
        .ACT_W  (ACT_W),
        .IDX_W  (IDX_W),
        .SCALE  (SCALE),
        .OFFSET (OFFSET)
    ) u_shf (
        .act_i      (act_i),
        .stage_en_i (stage_en),
        .mag_o      (mag)
    );

    assign mag_ext = PROD_W'(mag);
    assign prod_d  = negate ? -mag_ext : mag_ext;

    // product register between shifter and adder
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
            vld_q  <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            prod_q <= prod_d;
            vld_q  <= in_valid_i;
            clr_q  <= clr_i;
        end
    end

    lqpe_accum #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .vld_i       (vld_q),
        .clr_i       (clr_q),
        .prod_i      (prod_q),
        .acc_o       (acc_o),
        .out_valid_o (out_valid_o)
    );

endmodule

// File: rtl/lqpe_chk.sv
module lqpe_chk #(
    parameter int ACC_W  = 24,
    parameter int PROD_W = 19
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     vld_q,
    input logic                     clr_q,
    input logic signed [PROD_W-1:0] prod_q,
    input logic signed [ACC_W-1:0]  acc,
    input logic                     out_valid
);

    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (acc == '0 && !out_valid));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_q && !clr_q) |=> $stable(acc));

    // R6
    clear_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && clr_q) |=> (acc == ACC_W'($past(prod_q))));

    // R8
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !clr_q && acc == ACC_MAX && !prod_q[PROD_W-1]) |=> (acc == ACC_MAX));

    // R8
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !clr_q && acc == ACC_MIN && prod_q[PROD_W-1]) |=> (acc == ACC_MIN));

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R9
    invalid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

endmodule

bind lqpe_top lqpe_chk #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid_i),
    .vld_q     (vld_q),
    .clr_q     (clr_q),
    .prod_q    (prod_q),
    .acc       (acc_o),
    .out_valid (out_valid_o)
);

// File: tb/sim_lqpe_top.sv
`timescale 1ns/1ps
module sim_lqpe_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid_i = 1'b0;
    logic              clr_i = 1'b0;
    logic signed [7:0] act_i = '0;
    logic [3:0]        w_code_i = '0;
    logic signed [23:0] acc_o;
    logic              out_valid_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lqpe_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid_i),
        .clr_i       (clr_i),
        .act_i       (act_i),
        .w_code_i    (w_code_i),
        .acc_o       (acc_o),
        .out_valid_o (out_valid_o)
    );

    // {clear, activation, code, expected accumulator}
    localparam int NV = 10;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1,  8'sd10,   4'h2,  24'sd10},      // R2 e=0
        {1'b0,  8'sd10,   4'h3,  24'sd50},      // R2 e=2
        {1'b0, -8'sd3,    4'hC,  24'sd98},      // R4 -(-3*16)
        {1'b0,  8'sd7,    4'h0,  24'sd98},      // R3 7>>>4 = 0
        {1'b0, -8'sd1,    4'h0,  24'sd97},      // R3 floor(-1/16)
        {1'b0, -8'sd20,   4'h1,  24'sd92},      // R3 floor(-20/4)
        {1'b0,  8'sd100,  4'hD, -24'sd6308},    // R4 -(100*64)
        {1'b0, -8'sd128,  4'h7, -24'sd137380},  // R2 e=10
        {1'b0,  8'sd33,   4'h9, -24'sd137388},  // R3 R4 -(33>>>2)
        {1'b1,  8'sd5,    4'h6,  24'sd1280}     // R6 clear loads product
    };

    task automatic check(input string req, input logic signed [23:0] got,
                         input logic signed [23:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    // present one input for one cycle, return two edges later
    task automatic feed(input bit clr, input logic signed [7:0] a, input logic [3:0] c);
        @(negedge clk);
        in_valid_i = 1'b1; clr_i = clr; act_i = a; w_code_i = c;
        @(negedge clk);
        in_valid_i = 1'b0; clr_i = 1'b0; act_i = 8'sh5A; w_code_i = 4'hF;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 during and after reset
        repeat (3) @(negedge clk);
        check("R1 acc in reset", acc_o, 24'sd0);
        check("R1 valid in reset", {23'd0, out_valid_o}, 24'sd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 acc after reset", acc_o, 24'sd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            feed(VEC[i][36], VEC[i][35:28], VEC[i][27:24]);
            check($sformatf("R2/R3/R4/R6 vector %0d", i), acc_o, VEC[i][23:0]);
        end

        // R10 index 0 is 2^-4, not zero
        feed(1'b1, 8'sd16, 4'h0);
        check("R10 code 0 nonzero", acc_o, 24'sd1);

        // R5 idle cycles with garbage leave sum unchanged
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            act_i = 8'sh7F; w_code_i = 4'h7;
        end
        @(negedge clk);
        check("R5 idle hold", acc_o, 24'sd1);
        check("R5 no out valid", {23'd0, out_valid_o}, 24'sd0);

        // R9 latency
        @(negedge clk);
        in_valid_i = 1'b1; clr_i = 1'b1; act_i = 8'sd3; w_code_i = 4'h2;
        @(negedge clk);
        in_valid_i = 1'b0; clr_i = 1'b0;
        check("R9 acc after one edge", acc_o, 24'sd1);
        check("R9 valid after one edge", {23'd0, out_valid_o}, 24'sd0);
        @(negedge clk);
        check("R9 acc after two edges", acc_o, 24'sd3);
        check("R9 valid after two edges", {23'd0, out_valid_o}, 24'sd1);
        @(negedge clk);
        check("R9 valid single pulse", {23'd0, out_valid_o}, 24'sd0);

        // R7 clear without valid
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        @(negedge clk);
        check("R7 clear to zero", acc_o, 24'sd0);

        // R8 positive saturation: 70 streamed products of 127*1024
        @(negedge clk);
        in_valid_i = 1'b1; clr_i = 1'b1; act_i = 8'sd127; w_code_i = 4'h7;
        @(negedge clk);
        clr_i = 1'b0;
        repeat (69) @(negedge clk);
        in_valid_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 high limit", acc_o, 24'sd8388607);
        feed(1'b0, -8'sd16, 4'h2);
        check("R8 leaves high limit", acc_o, 24'sd8388591);

        // R8 negative saturation: 70 streamed products of -128*1024
        @(negedge clk);
        in_valid_i = 1'b1; clr_i = 1'b1; act_i = -8'sd128; w_code_i = 4'h7;
        @(negedge clk);
        clr_i = 1'b0;
        repeat (69) @(negedge clk);
        in_valid_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 low limit", acc_o, -24'sd8388608);
        feed(1'b0, 8'sd16, 4'h2);
        check("R8 leaves low limit", acc_o, -24'sd8388592);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", acc_o, 24'sd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule